// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to a next-hop value by longest-prefix match. The routing table lives in an on-chip node memory laid out as a binary trie. Each node word carries a left child index, a right child index, a prefix-marked flag and a next-hop value. A child index of zero means there is no child, so node 0 can only ever be the root.

A lookup starts at the root and tests one address bit per node, most significant bit first. A 0 bit follows the left child and a 1 bit follows the right child. As the walk goes down, the engine remembers the next hop of the deepest prefix-marked node it has passed. The walk ends when the needed child is missing or when all 32 bits have been used. The engine then reports the remembered next hop. A prefix-marked root acts as the default route 0/0.

Software loads the trie through a one-word-per-cycle write port. The engine holds one lookup at a time, and every node visited costs one synchronous memory read.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, req_ready is 1 and res_valid is 0.
- R2: For a trie holding prefixes of several lengths, the result carries the next hop of the longest stored prefix that matches the address, with res_found = 1.
- R3: Address bits are tested from bit 31 downward, one per trie level. A 0 bit selects the left child index and a 1 bit selects the right child index.
- R4: When the root node is prefix-marked and no longer prefix matches, the result is the root's next hop with res_found = 1 (default route).
- R5: When no visited node is prefix-marked, the result has res_found = 0 and res_hop = 0.
- R6: A child index of 0 means no child, and the walk stops at that node.
- R7: A 32-bit prefix is reachable. The walk stops after the node at depth 32 without testing further bits, so at most 33 nodes are read.
- R8: res_valid rises exactly N clock edges after the edge that accepted the request, where N is the number of nodes read (one read per node).
- R9: req_ready is 0 from acceptance until the cycle in which res_valid is 1. A request held during that time is not taken. res_valid is a single-cycle pulse that appears only for an accepted request.
- R10: A node write with wr_en = 1 replaces the whole node word at wr_idx, so later lookups see the new next hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle, so a request is accepted |
| req_addr | input | ADDR_W (32) | Destination address to look up |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | A stored prefix matched |
| res_hop | output | HOP_W (8) | Next hop of the longest match, 0 on a miss |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | NODE_AW (8) | Node index to write |
| wr_left | input | NODE_AW (8) | Left child index, 0 for none |
| wr_right | input | NODE_AW (8) | Right child index, 0 for none |
| wr_pfx | input | 1 | Node ends a stored prefix |
| wr_hop | input | HOP_W (8) | Next hop of that prefix |

## Verification
The bench uses the default parameters: a 32-bit address, 256 nodes with 8-bit indices, and 8-bit next hops. With 256 nodes, one trie can hold a full 33-node path for a /32 route next to a /31 sibling and a set of short prefixes from one to eight bits. This makes both the deepest walk, with its 33-cycle latency, and the one-read walk that stops at the root reachable in the same run. The width of the next-hop field leaves room for a distinct value per prefix, so a wrong choice among overlapping prefixes shows at the result port.

// File: rtl/trie_lpm_pkg.sv
`timescale 1ns/1ps
package trie_lpm_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/trie_node_mem.sv
`timescale 1ns/1ps
// Node storage: one write port, one registered read port.
module trie_node_mem #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 25
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= store[rd_idx];
        end
    end
endmodule

// File: rtl/trie_step_eval.sv
`timescale 1ns/1ps
// Combinational evaluation of one visited node.
module trie_step_eval #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 8,
    parameter int HOP_W   = 8,
    parameter int DEPTH_W = 6
) (
    input  logic [ADDR_W-1:0]  key,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [IDX_W-1:0]   node_left,
    input  logic [IDX_W-1:0]   node_right,
    input  logic               node_pfx,
    input  logic [HOP_W-1:0]   node_hop,
    input  logic               best_found,
    input  logic [HOP_W-1:0]   best_hop,
    output logic [IDX_W-1:0]   child_idx,
    output logic               descend,
    output logic               new_found,
    output logic [HOP_W-1:0]   new_hop
);
    logic [ADDR_W-1:0] aligned;
    logic              key_bit;
    logic              at_bottom;

    // Bring the bit under test to the top position.
    assign aligned   = key << depth;
    assign key_bit   = aligned[ADDR_W-1];
    assign at_bottom = (depth == DEPTH_W'(ADDR_W));
    assign child_idx = key_bit ? node_right : node_left;
    assign descend   = !at_bottom && (child_idx != '0);

    // A marked node is deeper than any earlier one, so it wins.
    assign new_found = best_found | node_pfx;
    assign new_hop   = node_pfx ? node_hop : best_hop;
endmodule

// File: rtl/trie_walk_ctrl.sv
`timescale 1ns/1ps
// Walk sequencer in two-process style.
module trie_walk_ctrl
    import trie_lpm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 8,
    parameter int HOP_W   = 8,
    parameter int DEPTH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   child_idx,
    input  logic               descend,
    input  logic               new_found,
    input  logic [HOP_W-1:0]   new_hop,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [ADDR_W-1:0]  key,
    output logic [DEPTH_W-1:0] depth,
    output logic               best_found,
    output logic [HOP_W-1:0]   best_hop,
    output logic               res_valid,
    output logic               res_found,
    output logic [HOP_W-1:0]   res_hop
);
    typedef struct packed {
        walk_state_e        state;
        logic [ADDR_W-1:0]  key;
        logic [DEPTH_W-1:0] depth;
        logic               best_found;
        logic [HOP_W-1:0]   best_hop;
        logic               res_valid;
        logic               res_found;
        logic [HOP_W-1:0]   res_hop;
    } walk_regs_t;

    walk_regs_t state_d, state_q;

    always_comb begin
        state_d           = state_q;
        state_d.res_valid = 1'b0;
        rd_en             = 1'b0;
        rd_idx            = '0;
        unique case (state_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    state_d.key        = req_addr;
                    state_d.depth      = '0;
                    state_d.best_found = 1'b0;
                    state_d.best_hop   = '0;
                    state_d.state      = WALK_BUSY;
                    rd_en              = 1'b1;
                    rd_idx             = '0;
                end
            end
            WALK_BUSY: begin
                state_d.best_found = new_found;
                state_d.best_hop   = new_hop;
                if (descend) begin
                    rd_en         = 1'b1;
                    rd_idx        = child_idx;
                    state_d.depth = state_q.depth + 1'b1;
                end else begin
                    state_d.res_valid = 1'b1;
                    state_d.res_found = new_found;
                    state_d.res_hop   = new_found ? new_hop : '0;
                    state_d.state     = WALK_IDLE;
                end
            end
            default: state_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{state: WALK_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready  = (state_q.state == WALK_IDLE);
    assign key        = state_q.key;
    assign depth      = state_q.depth;
    assign best_found = state_q.best_found;
    assign best_hop   = state_q.best_hop;
    assign res_valid  = state_q.res_valid;
    assign res_found  = state_q.res_found;
    assign res_hop    = state_q.res_hop;
endmodule

// File: rtl/trie_lpm_engine.sv
`timescale 1ns/1ps
// Longest-prefix lookup over a binary trie, one node per cycle.
module trie_lpm_engine #(
    parameter int ADDR_W  = 32,
    parameter int NODE_AW = 8,
    parameter int HOP_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               res_valid,
    output logic               res_found,
    output logic [HOP_W-1:0]   res_hop,
    input  logic               wr_en,
    input  logic [NODE_AW-1:0] wr_idx,
    input  logic [NODE_AW-1:0] wr_left,
    input  logic [NODE_AW-1:0] wr_right,
    input  logic               wr_pfx,
    input  logic [HOP_W-1:0]   wr_hop
);
    localparam int DEPTH_W = $clog2(ADDR_W + 1);
    localparam int WORD_W  = 2 * NODE_AW + 1 + HOP_W;

    logic [WORD_W-1:0]  wr_word;
    logic [WORD_W-1:0]  rd_word;
    logic               rd_en;
    logic [NODE_AW-1:0] rd_idx;
    logic [NODE_AW-1:0] n_left;
    logic [NODE_AW-1:0] n_right;
    logic               n_pfx;
    logic [HOP_W-1:0]   n_hop;
    logic [ADDR_W-1:0]  key;
    logic [DEPTH_W-1:0] depth;
    logic               best_found;
    logic [HOP_W-1:0]   best_hop;
    logic [NODE_AW-1:0] child_idx;
    logic               descend;
    logic               new_found;
    logic [HOP_W-1:0]   new_hop;

    // Node word: {left, right, prefix flag, next hop}.
    assign wr_word = {wr_left, wr_right, wr_pfx, wr_hop};
    assign n_left  = rd_word[WORD_W-1 -: NODE_AW];
    assign n_right = rd_word[HOP_W+NODE_AW -: NODE_AW];
    assign n_pfx   = rd_word[HOP_W];
    assign n_hop   = rd_word[HOP_W-1:0];

    trie_node_mem #(
        .IDX_W  (NODE_AW),
        .WORD_W (WORD_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    trie_step_eval #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (NODE_AW),
        .HOP_W   (HOP_W),
        .DEPTH_W (DEPTH_W)
    ) u_step (
        .key        (key),
        .depth      (depth),
        .node_left  (n_left),
        .node_right (n_right),
        .node_pfx   (n_pfx),
        .node_hop   (n_hop),
        .best_found (best_found),
        .best_hop   (best_hop),
        .child_idx  (child_idx),
        .descend    (descend),
        .new_found  (new_found),
        .new_hop    (new_hop)
    );

    trie_walk_ctrl #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (NODE_AW),
        .HOP_W   (HOP_W),
        .DEPTH_W (DEPTH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .child_idx  (child_idx),
        .descend    (descend),
        .new_found  (new_found),
        .new_hop    (new_hop),
        .rd_en      (rd_en),
        .rd_idx     (rd_idx),
        .key        (key),
        .depth      (depth),
        .best_found (best_found),
        .best_hop   (best_hop),
        .res_valid  (res_valid),
        .res_found  (res_found),
        .res_hop    (res_hop)
    );
endmodule

// File: rtl/trie_lpm_checker.sv
`timescale 1ns/1ps
// Port-level protocol checks, attached to the engine by bind.
module trie_lpm_checker #(
    parameter int ADDR_W = 32,
    parameter int HOP_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             res_valid,
    input logic             res_found,
    input logic [HOP_W-1:0] res_hop
);
    localparam int CNT_W = $clog2(ADDR_W + 3) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ADDR_W + 2);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (req_valid && req_ready) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (res_valid) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q && cnt_q != '1) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    a_r9_ready_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !res_valid) |-> !req_ready);

    a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> req_ready);

    a_r9_result_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r9_result_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy_q);

    a_r5_miss_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_found) |-> (res_hop == '0));

    a_r7_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CNT_MAX));
endmodule

bind trie_lpm_engine trie_lpm_checker #(
    .ADDR_W (ADDR_W),
    .HOP_W  (HOP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_found (res_found),
    .res_hop   (res_hop)
);

// File: tb/sim_trie_lpm_engine.sv
`timescale 1ns/1ps
module sim_trie_lpm_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        res_valid;
    logic        res_found;
    logic [7:0]  res_hop;
    logic        wr_en;
    logic [7:0]  wr_idx;
    logic [7:0]  wr_left;
    logic [7:0]  wr_right;
    logic        wr_pfx;
    logic [7:0]  wr_hop;

    int n_checks = 0;
    int n_errors = 0;

    // Bench copy of the trie it builds, plus the list of stored prefixes.
    int          t_left  [256];
    int          t_right [256];
    bit          t_pfx   [256];
    logic [7:0]  t_hop   [256];
    int          t_next;
    logic [31:0] p_bits  [64];
    int          p_len   [64];
    logic [7:0]  p_hop   [64];
    int          p_count;

    always #4 clk = ~clk;

    trie_lpm_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .res_valid (res_valid),
        .res_found (res_found),
        .res_hop   (res_hop),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_left   (wr_left),
        .wr_right  (wr_right),
        .wr_pfx    (wr_pfx),
        .wr_hop    (wr_hop)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_node(input int idx);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_idx   = 8'(idx);
        wr_left  = 8'(t_left[idx]);
        wr_right = 8'(t_right[idx]);
        wr_pfx   = t_pfx[idx];
        wr_hop   = t_hop[idx];
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic clear_trie();
        t_left[0] = 0; t_right[0] = 0; t_pfx[0] = 1'b0; t_hop[0] = 8'h00;
        t_next  = 1;
        p_count = 0;
        put_node(0);
    endtask

    // bits are left-aligned: bit 31 is the first bit tested.
    task automatic add_prefix(input logic [31:0] bits, input int len, input logic [7:0] hop);
        int cur = 0;
        bit replaced = 1'b0;
        for (int i = 0; i < len; i++) begin
            int nxt = bits[31-i] ? t_right[cur] : t_left[cur];
            if (nxt == 0) begin
                nxt = t_next++;
                t_left[nxt] = 0; t_right[nxt] = 0; t_pfx[nxt] = 1'b0; t_hop[nxt] = 8'h00;
                put_node(nxt);
                if (bits[31-i]) t_right[cur] = nxt; else t_left[cur] = nxt;
                put_node(cur);
            end
            cur = nxt;
        end
        t_pfx[cur] = 1'b1;
        t_hop[cur] = hop;
        put_node(cur);
        for (int k = 0; k < p_count; k++) begin
            if (p_len[k] == len && (len == 0 || (p_bits[k] >> (32 - len)) == (bits >> (32 - len)))) begin
                p_hop[k] = hop;
                replaced = 1'b1;
            end
        end
        if (!replaced) begin
            p_bits[p_count] = bits;
            p_len[p_count]  = len;
            p_hop[p_count]  = hop;
            p_count++;
        end
    endtask

    // Longest match over the prefix list; node reads = 1 + longest shared path.
    task automatic model(input logic [31:0] a, output bit found, output logic [7:0] hop,
                         output int reads);
        int best = -1;
        int deep = 0;
        found = 1'b0;
        hop   = 8'h00;
        for (int k = 0; k < p_count; k++) begin
            int common = 0;
            while (common < p_len[k] && p_bits[k][31-common] == a[31-common]) common++;
            if (common > deep) deep = common;
            if (common == p_len[k] && p_len[k] > best) begin
                best  = p_len[k];
                found = 1'b1;
                hop   = p_hop[k];
            end
        end
        reads = deep + 1;
    endtask

    task automatic lookup(input logic [31:0] a, input string req);
        bit         e_found;
        logic [7:0] e_hop;
        int         e_reads;
        int         edges = 0;
        model(a, e_found, e_hop, e_reads);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "ready low after acceptance", 64'(req_ready), 64'd0);
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end while (!res_valid && edges < 64);
        check("R8", $sformatf("latency for %08h", a), 64'(edges), 64'(e_reads));
        check(req, $sformatf("found flag for %08h", a), 64'(res_found), 64'(e_found));
        check(req, $sformatf("next hop for %08h", a), 64'(res_hop), 64'(e_hop));
        @(negedge clk);
        check("R9", "result strobe lasts one cycle", 64'(res_valid), 64'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        wr_en = 1'b0; wr_idx = '0; wr_left = '0; wr_right = '0; wr_pfx = 1'b0; wr_hop = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "req_ready after reset", 64'(req_ready), 64'd1);
        check("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    endtask

    task automatic test_no_default();
        clear_trie();
        add_prefix(32'h0800_0000, 5, 8'h10);   // 00001
        add_prefix(32'h2000_0000, 3, 8'h11);   // 001
        lookup(32'hF000_0000, "R5");            // root has no right child
        lookup(32'h4000_0000, "R6");            // 01: stops one level down
        lookup(32'h2ABC_0000, "R2");
        lookup(32'h0000_0000, "R5");            // 0000 0: path dead-ends, no mark
    endtask

    task automatic test_mixed_lengths();
        clear_trie();
        add_prefix(32'h0000_0000, 0, 8'h01);   // default route
        add_prefix(32'h0800_0000, 5, 8'h10);   // 00001
        add_prefix(32'h1000_0000, 5, 8'h12);   // 00010
        add_prefix(32'h1800_0000, 5, 8'h13);   // 00011
        add_prefix(32'h2000_0000, 3, 8'h11);   // 001
        add_prefix(32'h5000_0000, 4, 8'h14);   // 0101
        add_prefix(32'h6000_0000, 3, 8'h15);   // 011
        add_prefix(32'h8000_0000, 3, 8'h16);   // 100
        add_prefix(32'hA000_0000, 4, 8'h17);   // 1010
        add_prefix(32'hC000_0000, 4, 8'h18);   // 1100
        add_prefix(32'hF000_0000, 8, 8'h19);   // 11110000
        lookup(32'h0812_3456, "R2");
        lookup(32'h1F00_0000, "R2");
        lookup(32'h3000_0001, "R2");
        lookup(32'h5FFF_FFFF, "R2");
        lookup(32'hF0AB_CDEF, "R2");
        lookup(32'h2000_0000, "R3");            // 001 goes left, left, right
        lookup(32'h8000_0000, "R3");            // 100 goes right, left, left
        lookup(32'hF100_0000, "R4");
        lookup(32'h4000_0000, "R4");
        lookup(32'hE000_0000, "R4");
    endtask

    task automatic test_full_depth();
        add_prefix(32'hC0A8_0101, 32, 8'h55);
        add_prefix(32'hC0A8_0100, 31, 8'h54);
        lookup(32'hC0A8_0101, "R7");
        lookup(32'hC0A8_0100, "R7");
        lookup(32'hC0A8_0103, "R7");
    endtask

    task automatic test_busy_ignore();
        int edges = 0;
        bit extra = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'hC0A8_0101;
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_addr = 32'h0800_0000;           // competing request held while busy
            check("R9", "ready low while walking", 64'(req_ready), 64'd0);
            @(posedge clk);
            edges++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!res_valid && edges < 64) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        check("R9", "first request result hop", 64'(res_hop), 64'h55);
        check("R9", "first request latency", 64'(edges), 64'd33);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (res_valid) extra = 1'b1;
        end
        check("R9", "no result for request made while busy", 64'(extra), 64'd0);
        check("R9", "ready back high", 64'(req_ready), 64'd1);
    endtask

    task automatic test_update();
        add_prefix(32'h8000_0000, 3, 8'h66);
        lookup(32'h8000_0000, "R10");
        add_prefix(32'h0000_0000, 0, 8'h02);
        lookup(32'hE000_0000, "R10");
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        test_reset();
        test_no_default();
        test_mixed_lengths();
        test_full_depth();
        test_busy_ignore();
        test_update();
        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule